// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Receiver

This block receives one byte over a synchronous serial link in which it is the clock master. While a reception is under way it drives a divided shift clock onto an output pin, with an enable for a shared pin. On every rising edge of that clock it takes in one data bit. When all bits of the byte are in, it copies the byte into a receive buffer and raises a completion flag. Software starts a reception by holding the receive enable high while the flag is clear. It acknowledges the byte with a one-cycle clear pulse, and only then can another reception begin.

The end of a byte is not found with a bit counter. At start the shift register is loaded with all ones except a single zero in bit 0. Arriving bits push that zero upward. Once the zero sits in the top bit, the next sample is the last one. Two configuration inputs choose the idle level of the shift clock and the timing of a data-change strobe, which tells a transmit path when it may update its output bit. Both settings are captured when a reception starts.

Top module: `sync_shift_rx`

## Requirements
- R1: After reset, busy, flag, data-change strobe and pin enable are 0, the receive buffer is 0, and the shift clock is at the idle level selected by the idle-level input.
- R2: A reception starts at a clock edge only if receive enable is 1, the flag is 0 and no reception is running. While the flag is 1 or enable is 0, busy stays 0.
- R3: Busy rises at the first clock edge at which the start condition holds. The pin enable is 1 exactly while busy is 1.
- R4: Each bit present on the data input at a rising edge of the shift clock enters at bit 0 and moves one place up per later bit. The first bit received ends in bit W-1 of the buffer.
- R5: The shift register is preloaded with a single zero marker in bit 0. Reception ends after exactly W samples for any data, including all zeros and all ones. Flag, buffer and the fall of busy all update at the same edge, exactly W*DIV clocks after busy rose.
- R6: Idle-level input 0 gives a shift clock that rests high; input 1 gives a clock that rests low. Whenever busy is 0, the clock sits at that level.
- R7: Each shift-clock period lasts DIV system clocks. It spends its first DIV/2 clocks at the idle level and its last DIV/2 at the opposite level, starting from the edge at which busy rose.
- R8: With the hold-both input 0, the data-change strobe pulses for one clock right after each falling edge of the shift clock, W times per byte.
- R9: With the hold-both input 1, the strobe pulses DIV/4 clocks into each idle-level half period, while the clock is at its idle level and not changing, W times per byte.
- R10: A clear pulse drops the flag at the next edge. If a clear and a completion fall on the same edge, the flag is set.
- R11: Changes to the two configuration inputs while busy have no effect on the running reception.
- R12: Dropping receive enable during a reception does not abort it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable |
| rdone_clr_i | input | 1 | One-cycle pulse clearing the completion flag |
| cfg_idle_low_i | input | 1 | 0: shift clock rests high, 1: rests low |
| cfg_hold_both_i | input | 1 | 1: data-change strobe mid idle phase, 0: at falling edge |
| sdata_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Shift clock |
| sclk_oe_o | output | 1 | Drive enable for the shared clock pin |
| dchg_o | output | 1 | Data-change strobe for a transmit path |
| busy_o | output | 1 | Reception in progress |
| rdone_o | output | 1 | Completion flag |
| rbuf_o | output | W | Receive buffer |

## Verification
The bench sends all-zero and all-one bytes, because a marker scheme that compared against data instead of position would stop early or never stop on them. A wrong preload or a missing final shift shows up as a byte shifted by one place and a transfer length other than W*DIV clocks. The bench runs all four clock modes and checks the clock level in every cycle and the position of every strobe, so a swapped polarity or a strobe on the wrong edge is caught. It also checks a clear that lands on the completion edge, flips the configuration and drops the enable in the middle of a byte, and holds the enable high while the flag is set to confirm no reception starts.

// File: rtl/shrx_pkg.sv
package shrx_pkg;
  // Transfer configuration captured at the start of a reception.
  typedef struct packed {
    logic idle_low;   // 1: shift clock rests low
    logic hold_both;  // 1: change strobe in the middle of the idle phase
  } shrx_cfg_t;
endpackage

// File: rtl/shrx_clkgen.sv
module shrx_clkgen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle_low,
  input  logic hold_both,
  output logic sclk,
  output logic rise_evt,
  output logic end_evt,
  output logic dchg
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned QTR  = (HALF / 2 > 0) ? HALF / 2 : 1;
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dchg_q, dchg_d;
  logic          mid_evt, qtr_evt, fall_evt, active;

  // Events are decoded from the count before the edge they describe.
  assign mid_evt  = run & (cnt_q == CW'(HALF - 1));
  assign end_evt  = run & (cnt_q == CW'(DIV - 1));
  assign qtr_evt  = run & (cnt_q == CW'(QTR - 1));
  assign rise_evt = idle_low ? mid_evt : end_evt;
  assign fall_evt = idle_low ? end_evt : mid_evt;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (end_evt) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
    dchg_d = hold_both ? qtr_evt : fall_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dchg_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dchg_q <= dchg_d;
    end
  end

  assign active = run & (cnt_q >= CW'(HALF));
  assign sclk   = idle_low ? active : ~active;
  assign dchg   = dchg_q;
endmodule

// File: rtl/shrx_shifter.sv
module shrx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         rise_evt,
  input  logic         end_evt,
  input  logic         din,
  output logic         done,
  output logic [W-1:0] rbuf
);
  localparam logic [W-1:0] MARK = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] sr_q, sr_d, rbuf_q, rbuf_d;
  logic         fin_q, fin_d, last_shift;

  // The marker zero in the top bit means this sample is the final one.
  assign last_shift = rise_evt & ~sr_q[W-1];
  assign done       = end_evt & (fin_q | last_shift);

  always_comb begin
    sr_d   = sr_q;
    fin_d  = fin_q;
    rbuf_d = rbuf_q;
    if (load) begin
      sr_d  = MARK;
      fin_d = 1'b0;
    end else if (rise_evt) begin
      sr_d = {sr_q[W-2:0], din};
      if (last_shift) fin_d = 1'b1;
    end
    if (done) begin
      rbuf_d = sr_d;
      fin_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fin_q  <= 1'b0;
      rbuf_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fin_q  <= fin_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign rbuf = rbuf_q;
endmodule

// File: rtl/shrx_ctrl.sv
module shrx_ctrl
  import shrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_en,
  input  logic      clr,
  input  logic      done,
  input  shrx_cfg_t cfg_in,
  output logic      start,
  output logic      busy,
  output logic      flag,
  output shrx_cfg_t cfg
);
  logic      busy_q, busy_d, flag_q, flag_d;
  shrx_cfg_t cfg_q, cfg_d;

  assign start = rx_en & ~flag_q & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    flag_d = flag_q;
    cfg_d  = cfg_q;
    if (start) begin
      busy_d = 1'b1;
      cfg_d  = cfg_in;
    end else if (done) begin
      busy_d = 1'b0;
    end
    // Completion takes priority over a coincident clear.
    if (done)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      flag_q <= flag_d;
      cfg_q  <= cfg_d;
    end
  end

  assign busy = busy_q;
  assign flag = flag_q;
  assign cfg  = cfg_q;
endmodule

// File: rtl/sync_shift_rx.sv
module sync_shift_rx
  import shrx_pkg::*;
#(
  parameter int unsigned DIV = 8,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en_i,
  input  logic         rdone_clr_i,
  input  logic         cfg_idle_low_i,
  input  logic         cfg_hold_both_i,
  input  logic         sdata_i,
  output logic         sclk_o,
  output logic         sclk_oe_o,
  output logic         dchg_o,
  output logic         busy_o,
  output logic         rdone_o,
  output logic [W-1:0] rbuf_o
);
  shrx_cfg_t cfg_raw, cfg_q;
  logic      start, busy, flag, done;
  logic      rise_evt, end_evt, idle_low_eff;
  logic      cfg_idle_q, cfg_hold_q;

  assign cfg_raw.idle_low  = cfg_idle_low_i;
  assign cfg_raw.hold_both = cfg_hold_both_i;
  assign cfg_idle_q        = cfg_q.idle_low;
  assign cfg_hold_q        = cfg_q.hold_both;
  // Latched setting while busy, live setting for the resting level.
  assign idle_low_eff      = busy ? cfg_idle_q : cfg_idle_low_i;

  shrx_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_en  (rx_en_i),
    .clr    (rdone_clr_i),
    .done   (done),
    .cfg_in (cfg_raw),
    .start  (start),
    .busy   (busy),
    .flag   (flag),
    .cfg    (cfg_q)
  );

  shrx_clkgen #(.DIV(DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .idle_low  (idle_low_eff),
    .hold_both (cfg_hold_q),
    .sclk      (sclk_o),
    .rise_evt  (rise_evt),
    .end_evt   (end_evt),
    .dchg      (dchg_o)
  );

  shrx_shifter #(.W(W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .rise_evt (rise_evt),
    .end_evt  (end_evt),
    .din      (sdata_i),
    .done     (done),
    .rbuf     (rbuf_o)
  );

  assign sclk_oe_o = busy;
  assign busy_o    = busy;
  assign rdone_o   = flag;
endmodule

// File: rtl/sync_shift_rx_chk.sv
module sync_shift_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en_i,
  input logic rdone_clr_i,
  input logic sclk_o,
  input logic dchg_o,
  input logic busy_o,
  input logic rdone_o,
  input logic idle_q,
  input logic hold_q
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_i && !rdone_o && !busy_o |=> busy_o)
    else $error("start condition did not raise busy");

  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdone_o && !busy_o |=> !busy_o)
    else $error("reception started with flag set");

  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> rdone_o)
    else $error("busy fell without flag");

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (sclk_o == !idle_q))
    else $error("period did not start at idle level");

  p_fall_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_o && !hold_q |-> $fell(sclk_o))
    else $error("strobe not after falling edge");

  p_mid_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_o && hold_q |-> $stable(sclk_o) && (sclk_o == !idle_q))
    else $error("strobe not inside idle phase");

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdone_clr_i && rdone_o && !busy_o |=> !rdone_o)
    else $error("clear did not drop flag");
endmodule

bind sync_shift_rx sync_shift_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en_i     (rx_en_i),
  .rdone_clr_i (rdone_clr_i),
  .sclk_o      (sclk_o),
  .dchg_o      (dchg_o),
  .busy_o      (busy_o),
  .rdone_o     (rdone_o),
  .idle_q      (cfg_idle_q),
  .hold_q      (cfg_hold_q)
);

// File: tb/sync_shift_rx_tb.sv
module sync_shift_rx_tb;
  localparam int DIV  = 8;
  localparam int W    = 8;
  localparam int HALF = DIV / 2;
  localparam int QTR  = DIV / 4;

  logic clk, rst_n, rx_en_i, rdone_clr_i, cfg_idle_low_i, cfg_hold_both_i, sdata_i;
  logic sclk_o, sclk_oe_o, dchg_o, busy_o, rdone_o;
  logic [W-1:0] rbuf_o;
  int checks = 0;
  int errors = 0;

  sync_shift_rx #(.DIV(DIV), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .rdone_clr_i(rdone_clr_i),
    .cfg_idle_low_i(cfg_idle_low_i), .cfg_hold_both_i(cfg_hold_both_i),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .dchg_o(dchg_o),
    .busy_o(busy_o), .rdone_o(rdone_o), .rbuf_o(rbuf_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
    chk(rdone_o === 1'b0, "R1 flag", int'(rdone_o), 0);
    chk(rbuf_o === '0, "R1 rbuf", int'(rbuf_o), 0);
    chk(sclk_oe_o === 1'b0 && dchg_o === 1'b0, "R1 oe/strobe", int'({sclk_oe_o, dchg_o}), 0);
    chk(sclk_o === 1'b1, "R1 sclk idle", int'(sclk_o), 1);
  endtask

  task automatic t_idle_level();
    cfg_idle_low_i = 1'b1;
    @(negedge clk);
    chk(sclk_o === 1'b0, "R6 rest low", int'(sclk_o), 0);
    cfg_idle_low_i = 1'b0;
    @(negedge clk);
    chk(sclk_o === 1'b1, "R6 rest high", int'(sclk_o), 1);
  endtask

  // One full reception; first bit sent is b[W-1].
  task automatic t_rx(input logic [W-1:0] b, input bit idle_low, input bit hold,
                      input bit clr_hold, input bit flip_mid, input bit drop_en,
                      input string tag);
    int busy_n = 0, rises = 0, dchgs = 0, lvl_err = 0, oe_err = 0, chg_err = 0, pos = 0;
    bit prev, done = 0;
    bit idle_lvl = ~idle_low;
    if (rdone_o) begin
      rdone_clr_i = 1'b1;
      @(negedge clk);
      rdone_clr_i = 1'b0;
    end
    cfg_idle_low_i  = idle_low;
    cfg_hold_both_i = hold;
    sdata_i         = b[W-1];
    @(negedge clk);
    rdone_clr_i = clr_hold;
    prev    = sclk_o;
    rx_en_i = 1'b1;
    for (int i = 0; i < 4 * DIV * W && !done; i++) begin
      @(negedge clk);
      if (i == 0) chk(busy_o === 1'b1, {"R3 start latency ", tag}, int'(busy_o), 1);
      if (busy_o) begin
        busy_n++;
        pos = (busy_n - 1) % DIV;
        if (sclk_o !== (idle_lvl ^ (pos >= HALF))) lvl_err++;
        if (sclk_oe_o !== 1'b1) oe_err++;
      end else begin
        if (sclk_oe_o !== 1'b0) oe_err++;
        done = 1;
      end
      if (sclk_o && !prev) begin
        rises++;
        if (rises < W) sdata_i = b[W-1-rises];
      end
      if (dchg_o) begin
        dchgs++;
        if (hold) begin
          if (!busy_o || pos != QTR || sclk_o !== idle_lvl || sclk_o != prev) chg_err++;
        end else if (!(prev && !sclk_o)) chg_err++;
      end
      prev = sclk_o;
      if (flip_mid && busy_n == 4 * DIV) begin
        cfg_idle_low_i  = ~idle_low;
        cfg_hold_both_i = ~hold;
      end
      if (flip_mid && busy_n == 6 * DIV) begin
        cfg_idle_low_i  = idle_low;
        cfg_hold_both_i = hold;
      end
      if (drop_en && busy_n == 2 * DIV) rx_en_i = 1'b0;
    end
    chk(busy_n == W * DIV, {"R5 length ", tag}, busy_n, W * DIV);
    chk(rdone_o === 1'b1, {"R5 flag set ", tag}, int'(rdone_o), 1);
    if (clr_hold) chk(rdone_o === 1'b1, {"R10 set wins ", tag}, int'(rdone_o), 1);
    chk(rbuf_o === b, {"R4 data ", tag}, int'(rbuf_o), int'(b));
    chk(rises == W, {"R4 rises ", tag}, rises, W);
    chk(lvl_err == 0, {"R7 clock shape ", tag}, lvl_err, 0);
    if (flip_mid) chk(lvl_err == 0 && chg_err == 0, {"R11 cfg held ", tag}, lvl_err + chg_err, 0);
    if (drop_en) chk(busy_n == W * DIV, {"R12 no abort ", tag}, busy_n, W * DIV);
    chk(oe_err == 0, {"R3 pin enable ", tag}, oe_err, 0);
    if (hold) chk(dchgs == W && chg_err == 0, {"R9 strobe ", tag}, dchgs * 100 + chg_err, W * 100);
    else      chk(dchgs == W && chg_err == 0, {"R8 strobe ", tag}, dchgs * 100 + chg_err, W * 100);
    rx_en_i     = 1'b0;
    rdone_clr_i = 1'b0;
  endtask

  task automatic t_no_start();
    int bad = 0;
    rx_en_i = 1'b1;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (busy_o !== 1'b0 || sclk_oe_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 blocked by flag", bad, 0);
    rx_en_i     = 1'b0;
    rdone_clr_i = 1'b1;
    @(negedge clk);
    rdone_clr_i = 1'b0;
    chk(rdone_o === 1'b0, "R10 clear", int'(rdone_o), 0);
    bad = 0;
    for (int i = 0; i < DIV; i++) begin
      @(negedge clk);
      if (busy_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 no start without enable", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en_i = 1'b0; rdone_clr_i = 1'b0;
    cfg_idle_low_i = 1'b0; cfg_hold_both_i = 1'b0; sdata_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_level();
    t_rx(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "mode00");
    t_no_start();
    t_rx(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "mode10");
    t_rx(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "mode01 zeros");
    t_rx(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "mode11 ones");
    t_rx(8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "clear at end");
    t_rx(8'h4E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "cfg flip");
    t_rx(8'hD2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "enable drop");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule